// File: doc/BRIEF.md
# Load/Store Lane Steering Unit

This block sits between a memory data port one word wide and the register file of a processor. On a load it takes the aligned word read from memory, the low address bits, an access size, a sign select and a byte-order mode. It picks out the addressed byte, halfword or word, puts it at the right-hand end of the result, and fills the upper bits with zeros or with copies of the sign bit. On a store it does the reverse. It puts the low bytes of the store datum into the memory lanes that the address and byte order select, and it raises one byte-enable per lane written.

Both byte orders and both kinds of extension use one lane-index calculation, so the mode can change on every request. A halfword or word access that is not naturally aligned is not split into two accesses. The block raises a misalignment flag and suppresses the datum and the enables. The steering logic is combinational. An output register, selected by parameter, captures a result on each cycle that carries a valid request.

Top module: `lsx_lane_unit`

## Requirements
- R1: The read word presents the memory byte at address offset k in bits 8k+7:8k, in both modes. In little-endian mode (byte_order_big = 0) the access at offset o takes its least significant byte from lane o and its more significant bytes from the lanes above it. Example: word 0x78563412 gives 0x78563412 as a word, and 0x7856 as a halfword at offset 2.
- R2: In big-endian mode (byte_order_big = 1) the most significant byte of the access comes from the lowest-addressed lane. Example: word 0x78563412 gives 0x12345678 as a word, and 0x5678 as a halfword at offset 2.
- R3: With load_signed = 0, a byte load (acc_size = 2'b00) or a halfword load (acc_size = 2'b01) returns the datum in the low 8 or 16 bits and zeros in every bit above.
- R4: With load_signed = 1, the bits above a loaded byte are copies of result bit 7. The bits above a loaded halfword are copies of result bit 15.
- R5: A word load (acc_size = 2'b10 or 2'b11) returns all 32 bits and does not depend on load_signed.
- R6: A halfword access with offset bit 0 set, or a word access with a nonzero offset, sets misaligned and forces ld_result to zero. A byte access is never misaligned.
- R7: On a store, byte i of the datum (i = 0 is least significant) is written to lane o+i in little-endian mode and to lane o+n-1-i in big-endian mode, where n is the access width in bytes. Lanes that are not written carry zero in st_word.
- R8: st_byte_en bit k is 1 exactly for each lane k written by an aligned store: one bit for a byte, bits o and o+1 for a halfword, and all four bits for a word.
- R9: A misaligned access drives st_byte_en and st_word to zero.
- R10: With the default output register, the results and out_valid change one clock edge after a cycle with req_valid = 1. While req_valid is 0, out_valid is 0 and the results hold their values.
- R11: While rst_n is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| addr_lo | input | 2 | Byte offset of the access within the word |
| acc_size | input | 2 | 00 byte, 01 halfword, 1x word |
| load_signed | input | 1 | 1 sign-extends a narrow load, 0 zero-extends it |
| byte_order_big | input | 1 | 1 big-endian, 0 little-endian |
| rd_word | input | 32 | Aligned word read from memory |
| st_data | input | 32 | Store datum, right-justified |
| ld_result | output | 32 | Extracted and extended load datum |
| st_word | output | 32 | Store datum steered into memory lanes |
| st_byte_en | output | 4 | One enable per memory lane for the store |
| misaligned | output | 1 | Access offset does not match its size |
| out_valid | output | 1 | Outputs carry a new result |

## Verification
With the default output register, every result (ld_result, st_word, st_byte_en, misaligned and out_valid) is due after exactly one rising edge following a cycle in which req_valid is high. The bench drives each request on a falling edge. It holds the request for one period and reads the outputs on the next falling edge, after that single register stage, so each request is checked half a period after its capturing edge. The checks for R10 drop req_valid, change every other input, and read the outputs again one and two edges later. This confirms that nothing moved.

// File: rtl/lsx_pkg.sv
package lsx_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_HALF  = 2'b01,
        SZ_WORD  = 2'b10,
        SZ_WORD2 = 2'b11
    } size_e;

    // Width in bytes of an access; word means the full data path.
    function automatic int size_bytes(input size_e s, input int lanes);
        int n;
        unique case (s)
            SZ_BYTE: n = 1;
            SZ_HALF: n = 2;
            default: n = lanes;
        endcase
        return n;
    endfunction

    // Expand a per-lane enable into a bit mask.
    function automatic logic [31:0] lane_mask(input logic [3:0] be);
        logic [31:0] m;
        for (int k = 0; k < 4; k++) m[k*8 +: 8] = {8{be[k]}};
        return m;
    endfunction

endpackage

// File: rtl/lsx_misalign_chk.sv
module lsx_misalign_chk #(
    parameter int LANES = 4,
    localparam int OFF_W = $clog2(LANES)
) (
    input  logic [OFF_W-1:0]   offset,
    input  lsx_pkg::size_e     acc_size,
    output logic               misaligned
);
    int nb;

    always_comb begin
        nb = lsx_pkg::size_bytes(acc_size, LANES);
        misaligned = ((int'(offset) & (nb - 1)) != 0);
    end

endmodule

// File: rtl/lsx_load_extract.sv
module lsx_load_extract #(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int OFF_W = $clog2(LANES)
) (
    input  logic [DATA_W-1:0]  rd_word,
    input  logic [OFF_W-1:0]   offset,
    input  lsx_pkg::size_e     acc_size,
    input  logic               load_signed,
    input  logic               byte_order_big,
    input  logic               misaligned,
    output logic [DATA_W-1:0]  result
);
    logic [DATA_W-1:0] gathered;
    logic              sbit;
    int                nb;
    int                lane;

    always_comb begin
        nb = lsx_pkg::size_bytes(acc_size, LANES);
        gathered = '0;
        // Value byte i comes from lane o+i, or from lane o+n-1-i in big-endian mode.
        for (int i = 0; i < LANES; i++) begin
            if (byte_order_big) lane = int'(offset) + nb - 1 - i;
            else                lane = int'(offset) + i;
            lane = lane & (LANES - 1);
            gathered[i*8 +: 8] = rd_word[lane*8 +: 8];
        end
        sbit = gathered[nb*8 - 1];
        for (int i = 0; i < LANES; i++) begin
            if (i < nb) result[i*8 +: 8] = gathered[i*8 +: 8];
            else        result[i*8 +: 8] = {8{load_signed & sbit}};
        end
        if (misaligned) result = '0;
    end

endmodule

// File: rtl/lsx_store_steer.sv
module lsx_store_steer #(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int OFF_W = $clog2(LANES)
) (
    input  logic [DATA_W-1:0]  st_data,
    input  logic [OFF_W-1:0]   offset,
    input  lsx_pkg::size_e     acc_size,
    input  logic               byte_order_big,
    input  logic               misaligned,
    output logic [DATA_W-1:0]  st_word,
    output logic [LANES-1:0]   byte_en
);
    int nb;
    int rel;
    int idx;

    always_comb begin
        nb = lsx_pkg::size_bytes(acc_size, LANES);
        st_word = '0;
        byte_en = '0;
        for (int k = 0; k < LANES; k++) begin
            rel = k - int'(offset);
            idx = 0;
            if (rel >= 0 && rel < nb) begin
                idx = byte_order_big ? (nb - 1 - rel) : rel;
                byte_en[k] = 1'b1;
                st_word[k*8 +: 8] = st_data[idx*8 +: 8];
            end
        end
        if (misaligned) begin
            st_word = '0;
            byte_en = '0;
        end
    end

endmodule

// File: rtl/lsx_lane_unit.sv
module lsx_lane_unit #(
    parameter int DATA_W  = 32,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic [$clog2(DATA_W/8)-1:0]   addr_lo,
    input  logic [1:0]                    acc_size,
    input  logic                          load_signed,
    input  logic                          byte_order_big,
    input  logic [DATA_W-1:0]             rd_word,
    input  logic [DATA_W-1:0]             st_data,
    output logic [DATA_W-1:0]             ld_result,
    output logic [DATA_W-1:0]             st_word,
    output logic [DATA_W/8-1:0]           st_byte_en,
    output logic                          misaligned,
    output logic                          out_valid
);
    localparam int LANES = DATA_W / 8;

    lsx_pkg::size_e     sz;
    logic               c_mis;
    logic [DATA_W-1:0]  c_ld;
    logic [DATA_W-1:0]  c_st;
    logic [LANES-1:0]   c_be;

    assign sz = lsx_pkg::size_e'(acc_size);

    lsx_misalign_chk #(.LANES(LANES)) align_i (
        .offset     (addr_lo),
        .acc_size   (sz),
        .misaligned (c_mis)
    );

    lsx_load_extract #(.DATA_W(DATA_W)) load_i (
        .rd_word        (rd_word),
        .offset         (addr_lo),
        .acc_size       (sz),
        .load_signed    (load_signed),
        .byte_order_big (byte_order_big),
        .misaligned     (c_mis),
        .result         (c_ld)
    );

    AST_MIS_LOAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        c_mis |-> (c_ld == '0)); // R6
    AST_ZERO_FILL_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (!c_mis && sz == lsx_pkg::SZ_BYTE && !load_signed) |-> (c_ld[DATA_W-1:8] == '0)); // R3
    AST_ZERO_FILL_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (!c_mis && sz == lsx_pkg::SZ_HALF && !load_signed) |-> (c_ld[DATA_W-1:16] == '0)); // R3
    AST_SIGN_FILL_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (!c_mis && sz == lsx_pkg::SZ_BYTE && load_signed) |-> (c_ld[DATA_W-1:8] == {(DATA_W-8){c_ld[7]}})); // R4
    AST_SIGN_FILL_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (!c_mis && sz == lsx_pkg::SZ_HALF && load_signed) |-> (c_ld[DATA_W-1:16] == {(DATA_W-16){c_ld[15]}})); // R4

    lsx_store_steer #(.DATA_W(DATA_W)) store_i (
        .st_data        (st_data),
        .offset         (addr_lo),
        .acc_size       (sz),
        .byte_order_big (byte_order_big),
        .misaligned     (c_mis),
        .st_word        (c_st),
        .byte_en        (c_be)
    );

    AST_MIS_STORE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        c_mis |-> (c_be == '0 && c_st == '0)); // R9
    AST_BE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        !c_mis |-> ($countones(c_be) == lsx_pkg::size_bytes(sz, LANES))); // R8
    AST_STORE_IN_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (DATA_W != 32) || ((c_st & ~lsx_pkg::lane_mask(c_be[3:0])) == '0)); // R7

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    ld_result  <= '0;
                    st_word    <= '0;
                    st_byte_en <= '0;
                    misaligned <= 1'b0;
                    out_valid  <= 1'b0;
                end else begin
                    out_valid <= req_valid;
                    if (req_valid) begin
                        ld_result  <= c_ld;
                        st_word    <= c_st;
                        st_byte_en <= c_be;
                        misaligned <= c_mis;
                    end
                end
            end

            AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
                !req_valid |=> ($stable(ld_result) && $stable(st_word) && $stable(st_byte_en) && !out_valid)); // R10
            AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
                req_valid |=> out_valid); // R10
        end else begin : g_comb
            assign ld_result  = c_ld;
            assign st_word    = c_st;
            assign st_byte_en = c_be;
            assign misaligned = c_mis;
            assign out_valid  = req_valid;
        end
    endgenerate

endmodule

// File: tb/lsx_lane_unit_tb.sv
module lsx_lane_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  addr_lo = '0;
    logic [1:0]  acc_size = '0;
    logic        load_signed = 1'b0;
    logic        byte_order_big = 1'b0;
    logic [31:0] rd_word = '0;
    logic [31:0] st_data = '0;
    logic [31:0] ld_result;
    logic [31:0] st_word;
    logic [3:0]  st_byte_en;
    logic        misaligned;
    logic        out_valid;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    lsx_lane_unit dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .addr_lo(addr_lo),
        .acc_size(acc_size), .load_signed(load_signed), .byte_order_big(byte_order_big),
        .rd_word(rd_word), .st_data(st_data), .ld_result(ld_result), .st_word(st_word),
        .st_byte_en(st_byte_en), .misaligned(misaligned), .out_valid(out_valid)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one request at a falling edge, read the outputs one rising edge later.
    task automatic op(input logic [1:0] sz, input logic [1:0] off, input logic sgn,
                      input logic big, input logic [31:0] rd, input logic [31:0] sd);
        @(negedge clk);
        req_valid = 1'b1; acc_size = sz; addr_lo = off; load_signed = sgn;
        byte_order_big = big; rd_word = rd; st_data = sd;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic t_reset();
        check("R11 ld_result", ld_result, 32'h0);
        check("R11 st_word", st_word, 32'h0);
        check("R11 byte_en", {28'h0, st_byte_en}, 32'h0);
        check("R11 flags", {30'h0, misaligned, out_valid}, 32'h0);
    endtask

    task automatic t_little_loads();
        op(2'b10, 2'd0, 1'b0, 1'b0, 32'h78563412, 32'h0);
        check("R1 word LE", ld_result, 32'h78563412);
        check("R10 out_valid", {31'h0, out_valid}, 32'h1);
        op(2'b01, 2'd2, 1'b0, 1'b0, 32'h78563412, 32'h0);
        check("R1 half LE off2", ld_result, 32'h00007856);
        op(2'b00, 2'd1, 1'b0, 1'b0, 32'h78563412, 32'h0);
        check("R1 byte off1", ld_result, 32'h00000034);
    endtask

    task automatic t_big_loads();
        op(2'b10, 2'd0, 1'b0, 1'b1, 32'h78563412, 32'h0);
        check("R2 word BE", ld_result, 32'h12345678);
        op(2'b01, 2'd2, 1'b0, 1'b1, 32'h78563412, 32'h0);
        check("R2 half BE off2", ld_result, 32'h00005678);
        op(2'b01, 2'd0, 1'b0, 1'b1, 32'h78563412, 32'h0);
        check("R2 half BE off0", ld_result, 32'h00001234);
    endtask

    task automatic t_extension();
        op(2'b00, 2'd2, 1'b0, 1'b0, 32'h80FF7F01, 32'h0);
        check("R3 byte zero-ext", ld_result, 32'h000000FF);
        op(2'b00, 2'd2, 1'b1, 1'b0, 32'h80FF7F01, 32'h0);
        check("R4 byte sign-ext neg", ld_result, 32'hFFFFFFFF);
        op(2'b00, 2'd1, 1'b1, 1'b0, 32'h80FF7F01, 32'h0);
        check("R4 byte sign-ext pos", ld_result, 32'h0000007F);
        op(2'b01, 2'd2, 1'b0, 1'b0, 32'h80FF7F01, 32'h0);
        check("R3 half zero-ext", ld_result, 32'h000080FF);
        op(2'b01, 2'd2, 1'b1, 1'b0, 32'h80FF7F01, 32'h0);
        check("R4 half sign-ext LE", ld_result, 32'hFFFF80FF);
        op(2'b01, 2'd2, 1'b1, 1'b1, 32'h80FF7F01, 32'h0);
        check("R4 half sign-ext BE", ld_result, 32'hFFFFFF80);
        op(2'b01, 2'd0, 1'b1, 1'b0, 32'h80FF7F01, 32'h0);
        check("R4 half positive", ld_result, 32'h00007F01);
        op(2'b10, 2'd0, 1'b1, 1'b0, 32'h80FF7F01, 32'h0);
        check("R5 word signed", ld_result, 32'h80FF7F01);
        op(2'b11, 2'd0, 1'b0, 1'b0, 32'h80FF7F01, 32'h0);
        check("R5 word code 11", ld_result, 32'h80FF7F01);
    endtask

    task automatic t_misalign();
        op(2'b01, 2'd1, 1'b1, 1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF);
        check("R6 half off1 flag", {31'h0, misaligned}, 32'h1);
        check("R6 half off1 result", ld_result, 32'h0);
        check("R9 half off1 enables", {28'h0, st_byte_en}, 32'h0);
        check("R9 half off1 store", st_word, 32'h0);
        op(2'b10, 2'd2, 1'b0, 1'b1, 32'hFFFFFFFF, 32'hFFFFFFFF);
        check("R6 word off2 flag", {31'h0, misaligned}, 32'h1);
        check("R6 word off2 result", ld_result, 32'h0);
        op(2'b10, 2'd1, 1'b0, 1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF);
        check("R6 word off1 flag", {31'h0, misaligned}, 32'h1);
        op(2'b00, 2'd3, 1'b0, 1'b0, 32'hAB000000, 32'h0);
        check("R6 byte off3 flag", {31'h0, misaligned}, 32'h0);
        check("R6 byte off3 result", ld_result, 32'h000000AB);
    endtask

    task automatic t_stores();
        op(2'b00, 2'd3, 1'b0, 1'b0, 32'h0, 32'h0000ABCD);
        check("R7 byte off3", st_word, 32'hCD000000);
        check("R8 byte off3", {28'h0, st_byte_en}, 32'h8);
        op(2'b01, 2'd2, 1'b0, 1'b0, 32'h0, 32'h0000ABCD);
        check("R7 half LE off2", st_word, 32'hABCD0000);
        check("R8 half off2", {28'h0, st_byte_en}, 32'hC);
        op(2'b01, 2'd2, 1'b0, 1'b1, 32'h0, 32'h0000ABCD);
        check("R7 half BE off2", st_word, 32'hCDAB0000);
        op(2'b01, 2'd0, 1'b0, 1'b1, 32'h0, 32'hFFFFABCD);
        check("R7 half BE off0", st_word, 32'h0000CDAB);
        check("R8 half off0", {28'h0, st_byte_en}, 32'h3);
        op(2'b10, 2'd0, 1'b0, 1'b0, 32'h0, 32'h11223344);
        check("R7 word LE", st_word, 32'h11223344);
        check("R8 word", {28'h0, st_byte_en}, 32'hF);
        op(2'b10, 2'd0, 1'b0, 1'b1, 32'h0, 32'h11223344);
        check("R7 word BE", st_word, 32'h44332211);
    endtask

    task automatic t_hold();
        op(2'b01, 2'd0, 1'b0, 1'b0, 32'h0000BEEF, 32'h0000BEEF);
        check("R10 captured", ld_result, 32'h0000BEEF);
        acc_size = 2'b10; addr_lo = 2'd1; rd_word = 32'h12345678; st_data = 32'h55555555;
        @(negedge clk);
        check("R10 hold result", ld_result, 32'h0000BEEF);
        check("R10 hold store", st_word, 32'h0000BEEF);
        check("R10 hold enables", {28'h0, st_byte_en}, 32'h3);
        check("R10 hold misaligned", {31'h0, misaligned}, 32'h0);
        check("R10 valid low", {31'h0, out_valid}, 32'h0);
        @(negedge clk);
        check("R10 hold second edge", ld_result, 32'h0000BEEF);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #50000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_little_loads();
        t_big_loads();
        t_extension();
        t_misalign();
        t_stores();
        t_hold();
        finish_run();
    end

endmodule